// File: doc/BRIEF.md
# Bit-Slice Integer ALU

A purely combinational 32-bit arithmetic logic unit assembled from identical one-bit slices. Each slice can invert either operand. It forms the bitwise AND and OR of the conditioned operands and runs a full adder. A per-slice multiplexer then picks one of these or a shared "less" line. The ripple carry links neighbouring slices. A 4-bit operation code selects the operation. Its two upper bits directly steer operand inversion, and its two lower bits steer the result multiplexer.

The signed comparison is not a separate comparator. The top slice produces a "set" bit from its adder, corrected by the signed-overflow condition. That bit is routed back into the less input of slice 0, while every other slice sees a constant 0. NOR reuses the AND path with both operands inverted. The unit sits in an execution stage, taking two register operands and returning a result, a zero indication for branch decisions, and a signed overflow indication for trapping arithmetic.

Top module: `slice_alu`

## Requirements
- R1: Code 4'b0000 returns the bitwise AND of `opa` and `opb`.
- R2: Code 4'b0001 returns the bitwise OR of `opa` and `opb`.
- R3: Code 4'b0010 returns `opa + opb` modulo 2^32.
- R4: Code 4'b0110 returns `opa - opb` modulo 2^32, formed as `opa` plus the inverted `opb` plus 1.
- R5: Code 4'b0111 returns 1 in bit 0 when `opa` is less than `opb` as signed two's-complement values and 0 otherwise. Bits 31..1 are always 0, and the comparison is exact even when `opa - opb` overflows.
- R6: Code 4'b1100 returns the bitwise NOR of `opa` and `opb`.
- R7: For the six defined codes, `zero` is 1 exactly when all 32 result bits are 0.
- R8: Under code 4'b0010, `ovf` is 1 exactly when both operands have the same sign bit and the result's sign bit differs from it.
- R9: Under code 4'b0110, `ovf` is 1 exactly when the operand sign bits differ and the result's sign bit differs from that of `opa`. Under codes 0000, 0001, 0111 and 1100, `ovf` is 0.
- R10: Any other code gives a result of 0 with both `zero` and `ovf` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 4 | Operation select; bit 3 inverts A, bit 2 inverts B and sets carry-in |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| res | output | 32 | Operation result |
| zero | output | 1 | Result is all zeros (defined codes only) |
| ovf | output | 1 | Signed overflow of add or subtract |

## Verification
The block holds no state, so a fault in a slice, in the carry chain or in the set feedback appears on `res` in the same evaluation in which the operands are applied. A broken carry link shows up only for operand pairs whose carries cross that bit, which the random operands and the carry-saturating corners provoke. A wrong overflow correction of the set bit is visible only when `opa - opb` overflows, so the extreme signed values are driven under the comparison code. Stray control decoding shows up as a nonzero result or a raised flag under an unused code.

// File: rtl/slice_alu_pkg.sv
package slice_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'b0000,
        OP_OR  = 4'b0001,
        OP_ADD = 4'b0010,
        OP_SUB = 4'b0110,
        OP_SLT = 4'b0111,
        OP_NOR = 4'b1100
    } alu_op_e;

    typedef enum logic [1:0] {
        SEL_AND  = 2'b00,
        SEL_OR   = 2'b01,
        SEL_SUM  = 2'b10,
        SEL_LESS = 2'b11
    } slice_sel_e;

    typedef struct packed {
        logic       valid;
        logic       arith;
        logic       inv_a;
        logic       inv_b;
        slice_sel_e sel;
    } alu_ctrl_t;

    function automatic logic code_defined(input logic [3:0] code);
        case (code)
            OP_AND, OP_OR, OP_ADD, OP_SUB, OP_SLT, OP_NOR: return 1'b1;
            default:                                       return 1'b0;
        endcase
    endfunction

    function automatic alu_ctrl_t decode_op(input logic [3:0] code);
        alu_ctrl_t c;
        c.valid = code_defined(code);
        c.arith = (code == OP_ADD) || (code == OP_SUB);
        c.inv_a = code[3] & c.valid;
        c.inv_b = code[2] & c.valid;
        c.sel   = slice_sel_e'(code[1:0]);
        return c;
    endfunction

endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
    import slice_alu_pkg::*;
(
    input  logic       a,
    input  logic       b,
    input  logic       inv_a,
    input  logic       inv_b,
    input  logic       cin,
    input  logic       less,
    input  slice_sel_e sel,
    output logic       res,
    output logic       cout
);
    logic a_c, b_c, s;

    assign a_c  = inv_a ? ~a : a;
    assign b_c  = inv_b ? ~b : b;
    assign s    = a_c ^ b_c ^ cin;
    assign cout = (a_c & b_c) | (a_c & cin) | (b_c & cin);

    always_comb begin
        case (sel)
            SEL_AND:  res = a_c & b_c;
            SEL_OR:   res = a_c | b_c;
            SEL_SUM:  res = s;
            default:  res = less;
        endcase
    end
endmodule

// File: rtl/alu_top_set.sv
module alu_top_set (
    input  logic a_msb,
    input  logic b_msb,
    input  logic inv_a,
    input  logic inv_b,
    input  logic c_in_msb,
    input  logic c_out_msb,
    output logic ovf_raw,
    output logic set_bit
);
    logic sum_msb;

    assign sum_msb = (a_msb ^ inv_a) ^ (b_msb ^ inv_b) ^ c_in_msb;
    assign ovf_raw = c_in_msb ^ c_out_msb;
    assign set_bit = sum_msb ^ ovf_raw;
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] value,
    input  logic             enable,
    output logic             is_zero
);
    assign is_zero = enable & ~(|value);
endmodule

// File: rtl/slice_alu.sv
module slice_alu
    import slice_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [3:0]       op_code,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    output logic [WIDTH-1:0] res,
    output logic             zero,
    output logic             ovf
);
    localparam int MSB = WIDTH - 1;

    alu_ctrl_t        ctrl;
    logic [WIDTH:0]   carry;
    logic [WIDTH-1:0] less_vec;
    logic [WIDTH-1:0] slice_res;
    logic             ovf_raw;
    logic             set_bit;

    assign ctrl     = decode_op(op_code);
    assign carry[0] = ctrl.inv_b;
    assign less_vec = {{(WIDTH-1){1'b0}}, set_bit};

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        alu_bit_slice u_slice (
            .a     (opa[i]),
            .b     (opb[i]),
            .inv_a (ctrl.inv_a),
            .inv_b (ctrl.inv_b),
            .cin   (carry[i]),
            .less  (less_vec[i]),
            .sel   (ctrl.sel),
            .res   (slice_res[i]),
            .cout  (carry[i+1])
        );
    end

    alu_top_set u_set (
        .a_msb     (opa[MSB]),
        .b_msb     (opb[MSB]),
        .inv_a     (ctrl.inv_a),
        .inv_b     (ctrl.inv_b),
        .c_in_msb  (carry[MSB]),
        .c_out_msb (carry[WIDTH]),
        .ovf_raw   (ovf_raw),
        .set_bit   (set_bit)
    );

    assign res = ctrl.valid ? slice_res : '0;
    assign ovf = ovf_raw & ctrl.arith;

    alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
        .value   (res),
        .enable  (ctrl.valid),
        .is_zero (zero)
    );

    always_comb begin
        if (!$isunknown({op_code, opa, opb})) begin
            AST_SLT_UPPER_CLEAR: assert (op_code != OP_SLT || res[MSB:1] == '0) else $error("slt upper bits set"); // R5
            AST_ADD_OVF_SIGNS: assert (op_code != OP_ADD || !ovf || (opa[MSB] == opb[MSB] && res[MSB] != opa[MSB])) else $error("add ovf signs"); // R8
            AST_SUB_OVF_SIGNS: assert (op_code != OP_SUB || !ovf || (opa[MSB] != opb[MSB] && res[MSB] != opa[MSB])) else $error("sub ovf signs"); // R9
            AST_LOGIC_NO_OVF: assert (op_code == OP_ADD || op_code == OP_SUB || !ovf) else $error("ovf outside add/sub"); // R9
            AST_UNUSED_QUIET: assert (code_defined(op_code) || (res == '0 && !zero && !ovf)) else $error("unused code not quiet"); // R10
            AST_ZERO_MATCH: assert (!zero || res == '0) else $error("zero with nonzero result"); // R7
        end
    end
endmodule

// File: tb/test_slice_alu.sv
module test_slice_alu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op_code = 4'b0;
    logic [31:0] opa = 32'b0;
    logic [31:0] opb = 32'b0;
    logic [31:0] res;
    logic        zero;
    logic        ovf;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    slice_alu i_slice_alu (
        .op_code (op_code),
        .opa     (opa),
        .opb     (opb),
        .res     (res),
        .zero    (zero),
        .ovf     (ovf)
    );

    function automatic string req_of(input logic [3:0] c);
        case (c)
            4'b0000: return "R1";
            4'b0001: return "R2";
            4'b0010: return "R3/R8";
            4'b0110: return "R4/R9";
            4'b0111: return "R5";
            4'b1100: return "R6";
            default: return "R10";
        endcase
    endfunction

    function automatic logic [33:0] model(input logic [3:0] c, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] r;
        logic        v, z, d;
        v = 1'b0;
        d = 1'b1;
        case (c)
            4'b0000: r = a & b;
            4'b0001: r = a | b;
            4'b0010: begin r = a + b; v = (a[31] == b[31]) && (r[31] != a[31]); end
            4'b0110: begin r = a - b; v = (a[31] != b[31]) && (r[31] != a[31]); end
            4'b0111: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            4'b1100: r = ~(a | b);
            default: begin r = 32'd0; d = 1'b0; end
        endcase
        z = d && (r == 32'd0);
        return {r, z, v};
    endfunction

    task automatic check(input logic [3:0] c, input logic [31:0] a, input logic [31:0] b);
        logic [33:0] exp;
        @(posedge clk);
        #1;
        op_code = c;
        opa = a;
        opb = b;
        #2;
        exp = model(c, a, b);
        n_run++;
        if ({res, zero, ovf} !== exp) begin
            n_fail++;
            $display("FAIL %s (zero R7) code=%b a=%h b=%h: got res=%h zero=%b ovf=%b, expected res=%h zero=%b ovf=%b",
                     req_of(c), c, a, b, res, zero, ovf, exp[33:2], exp[1], exp[0]);
        end
    endtask

    initial begin
        logic [3:0] codes [6];
        codes = '{4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100};
        void'($urandom(32'd7131));
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // reset-state inputs: AND of zeros -> zero flag (R1, R7)
        check(4'b0000, 32'h0, 32'h0);
        // R1 R2 R6 directed
        check(4'b0000, 32'hF0F0_1234, 32'hFF00_FF0F);
        check(4'b0001, 32'hF0F0_0000, 32'h0000_000F);
        check(4'b1100, 32'h0000_0000, 32'h0000_0000);
        check(4'b1100, 32'hFFFF_FFFF, 32'h0000_0000);
        // R3 R8: full carry ripple, positive and negative overflow
        check(4'b0010, 32'hFFFF_FFFF, 32'h0000_0001);
        check(4'b0010, 32'h7FFF_FFFF, 32'h0000_0001);
        check(4'b0010, 32'h8000_0000, 32'h8000_0000);
        check(4'b0010, 32'h8000_0000, 32'h7FFF_FFFF);
        // R4 R9: equal operands give zero; overflow both directions
        check(4'b0110, 32'h1234_5678, 32'h1234_5678);
        check(4'b0110, 32'h8000_0000, 32'h0000_0001);
        check(4'b0110, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
        check(4'b0110, 32'h0000_0000, 32'h8000_0000);
        // R5: overflowing comparisons and equal operands
        check(4'b0111, 32'h8000_0000, 32'h0000_0001);
        check(4'b0111, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
        check(4'b0111, 32'hFFFF_FFFF, 32'h0000_0000);
        check(4'b0111, 32'h0000_0005, 32'h0000_0005);
        check(4'b0111, 32'h8000_0000, 32'h7FFF_FFFF);
        // R10: every unused code
        for (int k = 0; k < 16; k++) begin
            check(4'(k), 32'h0, 32'h0);
            check(4'(k), 32'hFFFF_FFFF, 32'h8000_0001);
        end
        // random mix over all defined codes
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a, b;
            a = $urandom();
            b = $urandom();
            if (i % 7 == 0) b = a;
            if (i % 11 == 0) a = {a[31], 31'h7FFF_FFFF};
            check(codes[$urandom_range(5, 0)], a, b);
        end
        for (int i = 0; i < 200; i++)
            check(4'($urandom()), $urandom(), $urandom());
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule